// File: doc/BRIEF.md
# Single-Wire Classification Bus Slave

This block is the endpoint that sits on the powered-device side of a single-wire, open-drain classification bus. The master pulls the shared line low to frame every transfer. The slave watches an oversampled copy of the line and owns one output that pulls the line low. A long low period marks the start of a frame, and the slave answers it with an acknowledge pulse. Each shorter low period opens a one-bit slot. The slot is timed from the master's falling edge by a counter inside the slave, so the slave needs no clock shared with the master.

The slot direction is set by local logic. While transmit bits are pending, each slot is a read slot and the slave returns its next bit. Otherwise each slot is a write slot and the slave samples the master's bit. Bytes received from the master are handed to local logic one at a time. Local logic can queue one byte for the master, or it can queue the whole 64-bit identity word. The identity word is captured while reset is held, and its check byte is verified at the same time.

All slot, reset and acknowledge timings are parameters counted in clock cycles. A slowed bus rate therefore needs only new parameter values.

Top module: `cls_bus_slave`

## Requirements
- R1: When the synchronised line has been low for RESET_CYC consecutive cycles, the slave pulses frame_start for one cycle. In the same step it abandons any slot in progress, discards a partially received byte and any pending transmit bits, and keeps drive_low deasserted while the master holds the line.
- R2: After the line is seen released following a reset, the slave waits ACK_WAIT_CYC cycles. It then asserts drive_low for ACK_CYC cycles as its acknowledge.
- R3: When no transmit bits are pending, a falling edge opens a write slot. The line is sampled SAMPLE_CYC cycles after the edge is detected: high gives bit 1 and low gives bit 0.
- R4: When transmit bits are pending, a falling edge opens a read slot. A bit value of 0 is returned by asserting drive_low from GLITCH_CYC to READ_HOLD_CYC cycles after the edge is detected. A bit value of 1 leaves the line released.
- R5: Bits move least-significant first. After every eighth write bit, rx_valid pulses for one cycle with the assembled byte on rx_byte.
- R6: A pulse on tx_load while tx_busy is low queues tx_byte for 8 read slots. A pulse on id_send has priority over tx_load and queues the captured identity word for 64 read slots. tx_busy stays high while queued bits remain. Either request is ignored while tx_busy is high.
- R7: While rst is high, id_word is captured. Its layout is: bits 7:0 class/type, bits 55:8 unique address, bits 63:56 check byte. crc_ok is set when bits 63:56 equal the CRC-8 of bits 55:0, fed least-significant bit first, using reflected polynomial 0x8C with initial value 0.
- R8: A low pulse that ends within GLITCH_CYC cycles of its falling edge does not count as a slot and leaves no bit behind.
- R9: While the slave drives the line, or before a slot has lasted SLOT_CYC cycles and the line has returned high, no new slot is opened. The slave's own edges therefore never count as master bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset; identity capture |
| bus_in | input | 1 | Raw level of the shared line |
| drive_low | output | 1 | Pull the shared line low when high |
| id_word | input | 64 | Strapped identity word |
| crc_ok | output | 1 | Identity check byte matches |
| frame_start | output | 1 | One-cycle pulse on reset recognition |
| rx_valid | output | 1 | One-cycle pulse, received byte ready |
| rx_byte | output | 8 | Last received byte |
| tx_load | input | 1 | Queue tx_byte for transmission |
| tx_byte | input | 8 | Byte to transmit |
| id_send | input | 1 | Queue the identity word for transmission |
| tx_busy | output | 1 | Transmit bits still pending |

## Verification
The assertions rely on a well-behaved master. It holds every slot low longer than GLITCH_CYC. It releases a write-1 before the sample point and a read slot before READ_HOLD_CYC. It spaces its falling edges more than SLOT_CYC apart, and it never starts a reset while an acknowledge is under way. The bench master uses fixed 150-cycle slots: 20-cycle lows for read and write-1 slots, 120-cycle lows for write-0 slots, and 500-cycle reset lows. All of these sit inside those limits for the scaled parameters it uses. Glitches are applied only as isolated 5-cycle lows.

// File: rtl/cls_bus_slave.sv
module cls_bus_slave #(
  parameter int GLITCH_CYC    = 10,
  parameter int SAMPLE_CYC    = 300,
  parameter int READ_HOLD_CYC = 300,
  parameter int SLOT_CYC      = 600,
  parameter int RESET_CYC     = 4800,
  parameter int ACK_WAIT_CYC  = 150,
  parameter int ACK_CYC       = 600
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_in,
  output logic        drive_low,
  input  logic [63:0] id_word,
  output logic        crc_ok,
  output logic        frame_start,
  output logic        rx_valid,
  output logic [7:0]  rx_byte,
  input  logic        tx_load,
  input  logic [7:0]  tx_byte,
  input  logic        id_send,
  output logic        tx_busy
);
  localparam int TW = $clog2(RESET_CYC + ACK_CYC + SLOT_CYC + 2);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_SLOT = 3'd1, S_RST = 3'd2,
    S_ACKW = 3'd3, S_ACK = 3'd4, S_ACKREL = 3'd5
  } st_t;

  st_t          st;
  logic         s1, s2, lq;
  logic [TW-1:0] tim, lowc;
  logic         rd;
  logic [63:0]  id_q, sh;
  logic [6:0]   txn;
  logic [7:0]   rsh;
  logic [2:0]   rxn;
  logic         drv;

  function automatic logic [7:0] crc8(input logic [55:0] d);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < 56; i++)
      c = (c[0] ^ d[i]) ? ((c >> 1) ^ 8'h8C) : (c >> 1);
    return c;
  endfunction

  wire fall    = lq & ~s2;
  wire hit_rst = ~s2 && (lowc == TW'(RESET_CYC - 1));

  assign drive_low = drv;
  assign tx_busy   = (txn != 7'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1; lq <= 1'b1;
      lowc <= '0;
    end else begin
      s1 <= bus_in; s2 <= s1; lq <= s2;
      if (s2) lowc <= '0;
      else if (lowc != TW'(RESET_CYC)) lowc <= lowc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; tim <= '0; rd <= 1'b0; drv <= 1'b0;
      txn <= '0; sh <= '0; rsh <= '0; rxn <= '0;
      rx_valid <= 1'b0; rx_byte <= '0; frame_start <= 1'b0;
      id_q <= id_word;
      crc_ok <= (crc8(id_word[55:0]) == id_word[63:56]);
    end else begin
      rx_valid    <= 1'b0;
      frame_start <= 1'b0;

      if (txn == 7'd0) begin
        if (id_send) begin
          sh <= id_q; txn <= 7'd64;
        end else if (tx_load) begin
          sh <= {56'b0, tx_byte}; txn <= 7'd8;
        end
      end

      if (hit_rst && (st == S_IDLE || st == S_SLOT)) begin
        st <= S_RST; drv <= 1'b0;
        txn <= '0; rxn <= '0;
        frame_start <= 1'b1;
      end else begin
        case (st)
          S_IDLE: if (fall) begin
            st <= S_SLOT; tim <= '0; rd <= (txn != 7'd0);
          end
          S_SLOT: begin
            tim <= tim + 1'b1;
            if (s2 && tim < TW'(GLITCH_CYC)) begin
              st <= S_IDLE; drv <= 1'b0;
            end else begin
              if (rd && tim == TW'(GLITCH_CYC - 1) && !sh[0]) drv <= 1'b1;
              if (rd && tim == TW'(READ_HOLD_CYC - 1)) begin
                drv <= 1'b0;
                sh  <= sh >> 1;
                txn <= txn - 1'b1;
              end
              if (!rd && tim == TW'(SAMPLE_CYC - 1)) begin
                rsh <= {s2, rsh[7:1]};
                rxn <= rxn + 1'b1;
                if (rxn == 3'd7) begin
                  rx_valid <= 1'b1;
                  rx_byte  <= {s2, rsh[7:1]};
                end
              end
              if (s2 && tim >= TW'(SLOT_CYC - 1)) st <= S_IDLE;
            end
          end
          S_RST: if (s2) begin
            st <= S_ACKW; tim <= '0;
          end
          S_ACKW: begin
            tim <= tim + 1'b1;
            if (tim == TW'(ACK_WAIT_CYC - 1)) begin
              st <= S_ACK; tim <= '0; drv <= 1'b1;
            end
          end
          S_ACK: begin
            tim <= tim + 1'b1;
            if (tim == TW'(ACK_CYC - 1)) begin
              st <= S_ACKREL; drv <= 1'b0;
            end
          end
          S_ACKREL: if (s2 && lq) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cls_bus_slave_chk.sv
module cls_bus_slave_chk #(
  parameter int ACK_CYC = 600
) (
  input logic       clk,
  input logic       rst,
  input logic       drive_low,
  input logic       frame_start,
  input logic       rx_valid,
  input logic       tx_busy,
  input logic [2:0] st,
  input logic       rd
);
  localparam logic [2:0] C_SLOT = 3'd1, C_RST = 3'd2, C_ACK = 3'd4, C_ACKREL = 3'd5;

  logic [31:0] run;
  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (drive_low) run <= run + 1;
    else run <= '0;
  end

  AST_RST_DROPS_TX: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !tx_busy); // R1
  AST_QUIET_IN_RST: assert property (@(posedge clk) disable iff (rst)
    (st == C_RST) |-> !drive_low); // R1
  AST_ACK_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == C_ACK && st == C_ACKREL) |-> (run >= ACK_CYC)); // R2
  AST_DRIVE_CONTEXT: assert property (@(posedge clk) disable iff (rst)
    drive_low |-> (st == C_ACK || (st == C_SLOT && rd))); // R4
  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R5
endmodule

bind cls_bus_slave cls_bus_slave_chk #(.ACK_CYC(ACK_CYC)) chk_i (
  .clk(clk), .rst(rst), .drive_low(drive_low), .frame_start(frame_start),
  .rx_valid(rx_valid), .tx_busy(tx_busy), .st(st), .rd(rd)
);

// File: tb/cls_bus_slave_tb.sv
module cls_bus_slave_tb_top;
  localparam int GL = 10, SAMP = 60, RH = 60, SLOT = 90, RSTC = 400, AW = 30, ACKC = 120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mlow = 1'b0;
  logic [63:0] id_word;
  logic tx_load = 1'b0, id_send = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  wire drive_low, crc_ok, frame_start, rx_valid, tx_busy;
  wire [7:0] rx_byte;
  wire bus = ~(mlow | drive_low);

  int n_tests = 0, n_fail = 0, rx_ev = 0, fr_ev = 0;
  logic [7:0] last_rx = 8'h00;
  logic hold_ok;

  always #10 clk = ~clk;

  cls_bus_slave #(.GLITCH_CYC(GL), .SAMPLE_CYC(SAMP), .READ_HOLD_CYC(RH), .SLOT_CYC(SLOT),
                  .RESET_CYC(RSTC), .ACK_WAIT_CYC(AW), .ACK_CYC(ACKC)) dut_i (
    .clk(clk), .rst(rst), .bus_in(bus), .drive_low(drive_low), .id_word(id_word),
    .crc_ok(crc_ok), .frame_start(frame_start), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_load(tx_load), .tx_byte(tx_byte), .id_send(id_send), .tx_busy(tx_busy));

  always @(negedge clk) begin
    if (!rst && rx_valid) begin rx_ev++; last_rx = rx_byte; end
    if (!rst && frame_start) fr_ev++;
  end

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic fb = c[0] ^ d[i];
      c = {1'b0, c[7:1]};
      if (fb) c = c ^ 8'h8C;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic slot_write(input logic b);
    mlow = 1'b1; wait_n(b ? 20 : 120);
    mlow = 1'b0; wait_n(b ? 130 : 30);
  endtask

  task automatic slot_read(output logic b);
    mlow = 1'b1; wait_n(20);
    mlow = 1'b0; wait_n(20);
    b = bus;
    wait_n(RH - 1 - 40);
    if (b == 1'b0 && bus !== 1'b0) hold_ok = 1'b0;
    wait_n(150 - RH + 1);
  endtask

  task automatic write_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) slot_write(v[i]);
  endtask

  task automatic read_byte(output logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      logic b;
      slot_read(b);
      v[i] = b;
    end
  endtask

  task automatic load_tx(input logic [7:0] v);
    tx_byte = v; tx_load = 1'b1; wait_n(1); tx_load = 1'b0; wait_n(2);
  endtask

  task automatic master_reset(input string tag);
    int drv_early = 0, wait_c = 0, ack_len = 0, fr0;
    fr0 = fr_ev;
    mlow = 1'b1;
    for (int i = 0; i < 500; i++) begin
      wait_n(1);
      if (drive_low) drv_early++;
    end
    mlow = 1'b0;
    while (!drive_low && wait_c < 200) begin wait_n(1); wait_c++; end
    while (drive_low && ack_len < 1000) begin wait_n(1); ack_len++; end
    wait_n(30);
    chk({tag, " R1 frame_start pulses"}, fr_ev - fr0, 1);
    chk({tag, " R1 no drive during master reset"}, drv_early, 0);
    chk({tag, " R2 ack wait at least ACK_WAIT"}, wait_c >= AW, 1);
    chk({tag, " R2 ack length at least ACK_CYC"}, ack_len >= ACKC, 1);
  endtask

  task automatic t_reset_state();
    chk("R7 crc_ok after reset", crc_ok, 1);
    chk("R6 tx_busy idle after reset", tx_busy, 0);
    chk("R4 drive_low idle after reset", drive_low, 0);
    chk("R5 rx_valid idle after reset", rx_valid, 0);
  endtask

  task automatic t_write();
    int e0 = rx_ev;
    write_byte(8'hA5);
    chk("R3 R5 byte A5 received", last_rx, 8'hA5);
    write_byte(8'h3C);
    chk("R3 R5 byte 3C received", last_rx, 8'h3C);
    chk("R5 two byte events", rx_ev - e0, 2);
  endtask

  task automatic t_partial();
    int e0;
    slot_write(1'b1); slot_write(1'b0); slot_write(1'b1);
    master_reset("partial");
    e0 = rx_ev;
    write_byte(8'h81);
    chk("R1 partial byte discarded", last_rx, 8'h81);
    chk("R1 one byte after discard", rx_ev - e0, 1);
  endtask

  task automatic t_glitch();
    int e0 = rx_ev;
    for (int i = 0; i < 4; i++) slot_write(8'h96 >> i);
    mlow = 1'b1; wait_n(5); mlow = 1'b0; wait_n(150);
    for (int i = 4; i < 8; i++) slot_write(8'h96 >> i);
    chk("R8 glitch leaves no bit", last_rx, 8'h96);
    chk("R8 one byte across glitch", rx_ev - e0, 1);
  endtask

  task automatic t_read();
    logic [7:0] v;
    int e0 = rx_ev;
    hold_ok = 1'b1;
    load_tx(8'h6A);
    chk("R6 tx_busy after load", tx_busy, 1);
    read_byte(v);
    chk("R4 R5 read byte 6A LSB first", v, 8'h6A);
    chk("R4 read-0 held to READ_HOLD", hold_ok, 1);
    chk("R6 tx_busy clears after 8 slots", tx_busy, 0);
    chk("R9 read slots give no rx bytes", rx_ev - e0, 0);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    load_tx(8'h0F);
    load_tx(8'hF0);
    id_send = 1'b1; wait_n(1); id_send = 1'b0;
    read_byte(v);
    chk("R6 load ignored while busy", v, 8'h0F);
    chk("R6 idle after ignored loads", tx_busy, 0);
  endtask

  task automatic t_id();
    logic [63:0] got;
    tx_byte = 8'h55; tx_load = 1'b1; id_send = 1'b1; wait_n(1);
    tx_load = 1'b0; id_send = 1'b0; wait_n(2);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] v;
      read_byte(v);
      got[k*8 +: 8] = v;
    end
    chk("R6 identity word shifted out", got, id_word);
    chk("R6 idle after identity", tx_busy, 0);
  endtask

  task automatic t_own_edges();
    logic [7:0] v;
    int e0 = rx_ev;
    load_tx(8'h00);
    read_byte(v);
    chk("R4 all-zero byte read", v, 8'h00);
    write_byte(8'h5A);
    chk("R9 own edges not counted", last_rx, 8'h5A);
    chk("R9 single byte after reads", rx_ev - e0, 1);
  endtask

  task automatic t_tx_abort();
    logic b;
    load_tx(8'hFF);
    slot_read(b); slot_read(b);
    master_reset("abort");
    chk("R1 pending tx dropped by reset", tx_busy, 0);
  endtask

  task automatic t_crc();
    logic [63:0] good = id_word;
    id_word = good ^ 64'h0100_0000_0000_0000;
    rst = 1'b1; wait_n(3); rst = 1'b0; wait_n(3);
    chk("R7 bad check byte flagged", crc_ok, 0);
    id_word = good;
    rst = 1'b1; wait_n(3); rst = 1'b0; wait_n(3);
    chk("R7 good check byte accepted", crc_ok, 1);
  endtask

  initial begin
    id_word[55:0] = 56'hC0FFEE_1234_56_3D;
    id_word[63:56] = ref_crc(id_word[55:0]);
    wait_n(5);
    rst = 1'b0;
    wait_n(5);
    t_reset_state();
    master_reset("first");
    t_write();
    t_partial();
    t_glitch();
    t_read();
    t_busy_ignore();
    t_id();
    t_own_edges();
    t_tx_abort();
    t_crc();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule